// File: doc/BRIEF.md
# Priority Pin Function Multiplexer

This block picks which on-chip signal drives each of a small set of pads. Every pad offers five prioritised signal slots plus a fallback slot. A slot is claimed by a rule held in a synthesis-time table. A rule is an OR of up to two expressions, and each expression is an AND of up to four masked field compares. A compare can look at any of four writable 32-bit control words or at a read-only strap word. The strap word is captured from input pins while reset is held. The fallback slot is not tied to GPIO; a GPIO signal may sit in a prioritised slot with its own rule.

The winning slot index is registered once per clock. The index drives a one-hot select, an encoded level, and a combinational mux. That mux steers the chosen function's output and output-enable onto the pad. Software writes the control words through a simple write port. It reads back the control words, the captured strap word and a per-pad status word through a combinational read port.

Top module: `pinfunc_mux`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), every control word is cleared and every pad reports level 5 (fallback). All control words read back as zero after reset.
- R2: Address map: 0 to 3 are the control words, 4 is the strap word, and 5 to 8 are the status words of pads 0 to 3. Other addresses read zero. A write with wr_en high to address 0 to 3 is visible on rd_data from the next clock. Writes to addresses 4 and above change nothing.
- R3: The strap word takes the value of strap_pins at every clock edge with rst_n low. It holds that value while rst_n is high, whatever strap_pins does.
- R4: A compare term carries a mask and a right-aligned expected value. The expected value is shifted up to the lowest set bit of the mask, so multi-bit fields and required-zero bits work. Example: a term on bits 5:4 with value 3 passes only for field value 3.
- R5: An expression is true only when every enabled term in it is true. An expression marked unused never fires.
- R6: A priority level fires when any of its used expressions is true.
- R7: The pad's level is the lowest-numbered firing level (0 highest). It is 5 when no level fires.
- R8: A level whose rule depends on the strap word follows the captured strap value. It cannot be switched off or on by control writes alone.
- R9: The level is registered. It reflects the control words as they stood before the previous clock edge, so a write appears on the pad level two edges after it is presented. pad_sel for pad p is one-hot, with bit index equal to the level.
- R10: pad_out[p] equals fn_out[p*6+level] and pad_oe[p] equals fn_oe[p*6+level], combinationally from the function inputs.
- R11: Reading status address 5+p returns the current level of pad p, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap capture window |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data (combinational) |
| strap_pins | input | 32 | Strap pin levels, captured during reset |
| fn_out | input | 24 | Function outputs, slot s of pad p at bit p*6+s |
| fn_oe | input | 24 | Function output-enables, same layout |
| pad_out | output | 4 | Pad output per pad |
| pad_oe | output | 4 | Pad output-enable per pad |
| pad_sel | output | 24 | One-hot slot select, pad p at bits p*6 +: 6 |
| pad_level | output | 12 | Encoded level 0..5, pad p at bits p*3 +: 3 |

## Verification
The hardest states to reach are the deep levels of the video-style pad. Level 4 on pad 3 needs a 2-bit field at exactly 2, and it needs levels 0 to 3 all false at once. Those higher levels share control bits and a strap bit. A second hard case is a strap-enabled level that no write can clear. The stimulus covers both with directed write sequences under two reset phases that capture opposite strap bits. Long random write runs follow, biased toward the decoded control bits and fields, and a behavioural model of each pad's rules is compared every clock.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_CTRL = 4;
  localparam int N_PADS   = 4;
  localparam int N_LEVELS = 5;
  localparam int N_SEL    = N_LEVELS + 1;
  localparam int LVL_W    = $clog2(N_SEL);
  localparam int N_EXPRS  = 2;
  localparam int N_TERMS  = 4;
  localparam int SRC_W    = $clog2(NUM_CTRL + 1);
  localparam logic [SRC_W-1:0] SRC_STRAP = SRC_W'(NUM_CTRL);
  localparam logic [LVL_W-1:0] FALLBACK  = LVL_W'(N_LEVELS);

  typedef struct packed {
    logic             en;
    logic [SRC_W-1:0] src;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] val;
  } cond_t;

  typedef struct packed {
    logic                      used;
    cond_t [N_TERMS-1:0]       conds;
  } expr_t;

  typedef expr_t [N_EXPRS-1:0]       level_rule_t;
  typedef level_rule_t [N_LEVELS-1:0] pad_rule_t;
  typedef pad_rule_t [N_PADS-1:0]     rule_table_t;

  // Shift a right-aligned value up to the lowest set bit of its mask.
  function automatic logic [REG_W-1:0] align_value(input logic [REG_W-1:0] mask,
                                                   input logic [REG_W-1:0] val);
    int sh;
    sh = 0;
    for (int i = REG_W - 1; i >= 0; i--) if (mask[i]) sh = i;
    return (val << sh) & mask;
  endfunction

  function automatic logic cond_true(input cond_t c, input logic [REG_W-1:0] word);
    return (word & c.mask) == align_value(c.mask, c.val);
  endfunction

  // Lowest-numbered firing level wins; fallback when none fires.
  function automatic logic [LVL_W-1:0] first_active(input logic [N_LEVELS-1:0] hit);
    logic [LVL_W-1:0] r;
    r = FALLBACK;
    for (int i = N_LEVELS - 1; i >= 0; i--) if (hit[i]) r = LVL_W'(i);
    return r;
  endfunction

  function automatic cond_t mk(input int src, input int lo, input int width, input int val);
    cond_t c;
    c      = '0;
    c.en   = 1'b1;
    c.src  = SRC_W'(src);
    for (int i = 0; i < width; i++) c.mask[lo + i] = 1'b1;
    c.val  = REG_W'(val);
    return c;
  endfunction

  function automatic rule_table_t default_rules();
    rule_table_t t;
    t = '0;
    // pad 0: one gated signal
    t[0][0][0].used = 1'b1; t[0][0][0].conds[0] = mk(0, 0, 1, 1);
    // pad 1: high signal, then a low signal reachable by control bit or strap bit
    t[1][0][0].used = 1'b1; t[1][0][0].conds[0] = mk(1, 22, 1, 1);
    t[1][1][0].used = 1'b1; t[1][1][0].conds[0] = mk(0, 12, 1, 1);
    t[1][1][1].used = 1'b1; t[1][1][1].conds[0] = mk(NUM_CTRL, 14, 1, 1);
    // pad 2: two signals sharing two bits, split by a third; GPIO at level 2
    t[2][0][0].used = 1'b1;
    t[2][0][0].conds[0] = mk(2, 3, 1, 1);
    t[2][0][0].conds[1] = mk(0, 15, 1, 1);
    t[2][0][0].conds[2] = mk(3, 31, 1, 0);
    t[2][1][0].used = 1'b1;
    t[2][1][0].conds[0] = mk(2, 3, 1, 1);
    t[2][1][0].conds[1] = mk(0, 15, 1, 1);
    t[2][1][0].conds[2] = mk(3, 31, 1, 1);
    t[2][2][0].used = 1'b1; t[2][2][0].conds[0] = mk(0, 1, 1, 1);
    // pad 3: video mode field ctrl3[5:4] and shared enable ctrl1[17]
    t[3][0][0].used = 1'b1;
    t[3][0][0].conds[0] = mk(3, 5, 1, 1);
    t[3][0][0].conds[1] = mk(1, 17, 1, 1);
    t[3][0][1].used = 1'b1;
    t[3][0][1].conds[0] = mk(3, 4, 1, 1);
    t[3][0][1].conds[1] = mk(1, 17, 1, 1);
    t[3][1][0].used = 1'b1;
    t[3][1][0].conds[0] = mk(3, 4, 2, 3);
    t[3][1][0].conds[1] = mk(1, 18, 1, 1);
    t[3][2][0].used = 1'b1; t[3][2][0].conds[0] = mk(1, 17, 1, 1);
    t[3][3][0].used = 1'b1;
    t[3][3][0].conds[0] = mk(NUM_CTRL, 19, 1, 0);
    t[3][3][0].conds[1] = mk(0, 25, 1, 1);
    t[3][4][0].used = 1'b1; t[3][4][0].conds[0] = mk(2, 6, 2, 2);
    return t;
  endfunction
endpackage

// File: rtl/pfm_regfile.sv
module pfm_regfile
  import pfm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [REG_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [REG_W-1:0]            strap_pins,
  input  logic [N_PADS*LVL_W-1:0]     levels,
  output logic [NUM_CTRL*REG_W-1:0]   ctrl_flat,
  output logic [REG_W-1:0]            strap_q,
  output logic [REG_W-1:0]            rd_data
);
  localparam int STRAP_ADDR = NUM_CTRL;
  localparam int STAT_BASE  = NUM_CTRL + 1;

  logic [REG_W-1:0] ctrl_q [NUM_CTRL];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n)                                  ctrl_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))     ctrl_q[i] <= wr_data;
    end
    assign ctrl_flat[i*REG_W +: REG_W] = ctrl_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_pins;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = ctrl_q[i];
    if (rd_addr == ADDR_W'(STRAP_ADDR)) rd_data = strap_q;
    for (int p = 0; p < N_PADS; p++)
      if (rd_addr == ADDR_W'(STAT_BASE + p))
        rd_data = REG_W'(levels[p*LVL_W +: LVL_W]);
  end
endmodule

// File: rtl/pfm_pad_eval.sv
module pfm_pad_eval
  import pfm_pkg::*;
#(
  parameter pad_rule_t RULE = '0
) (
  input  logic [(NUM_CTRL+1)*REG_W-1:0] words,
  output logic [N_LEVELS-1:0]           hit
);
  function automatic logic [REG_W-1:0] pick(input logic [(NUM_CTRL+1)*REG_W-1:0] w,
                                            input logic [SRC_W-1:0] s);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i <= NUM_CTRL; i++) if (s == SRC_W'(i)) r = w[i*REG_W +: REG_W];
    return r;
  endfunction

  for (genvar l = 0; l < N_LEVELS; l++) begin : g_lvl
    logic [N_EXPRS-1:0] expr_ok;
    for (genvar e = 0; e < N_EXPRS; e++) begin : g_expr
      logic [N_TERMS-1:0] term_ok;
      for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        localparam cond_t C = RULE[l][e].conds[t];
        assign term_ok[t] = !C.en || cond_true(C, pick(words, C.src));
      end
      assign expr_ok[e] = RULE[l][e].used && (&term_ok);
    end
    assign hit[l] = |expr_ok;
  end
endmodule

// File: rtl/pfm_pad_select.sv
module pfm_pad_select
  import pfm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LEVELS-1:0] hit,
  input  logic [N_SEL-1:0]    fn_out,
  input  logic [N_SEL-1:0]    fn_oe,
  output logic [LVL_W-1:0]    level_q,
  output logic [N_SEL-1:0]    sel_onehot,
  output logic                pad_out,
  output logic                pad_oe
);
  logic [LVL_W-1:0] level_next;
  assign level_next = first_active(hit);

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= FALLBACK;
    else        level_q <= level_next;
  end

  always_comb begin
    sel_onehot = '0;
    pad_out    = 1'b0;
    pad_oe     = 1'b0;
    for (int s = 0; s < N_SEL; s++) begin
      if (level_q == LVL_W'(s)) begin
        sel_onehot[s] = 1'b1;
        pad_out       = fn_out[s];
        pad_oe        = fn_oe[s];
      end
    end
  end
endmodule

// File: rtl/pinfunc_mux.sv
module pinfunc_mux
  import pfm_pkg::*;
#(
  parameter int          ADDR_W = 4,
  parameter rule_table_t RULES  = default_rules()
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  input  logic [REG_W-1:0]        strap_pins,
  input  logic [N_PADS*N_SEL-1:0] fn_out,
  input  logic [N_PADS*N_SEL-1:0] fn_oe,
  output logic [N_PADS-1:0]       pad_out,
  output logic [N_PADS-1:0]       pad_oe,
  output logic [N_PADS*N_SEL-1:0] pad_sel,
  output logic [N_PADS*LVL_W-1:0] pad_level
);
  logic [NUM_CTRL*REG_W-1:0]     ctrl_flat;
  logic [REG_W-1:0]              strap_q;
  logic [(NUM_CTRL+1)*REG_W-1:0] words;

  assign words = {strap_q, ctrl_flat};

  pfm_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .strap_pins(strap_pins), .levels(pad_level),
    .ctrl_flat(ctrl_flat), .strap_q(strap_q), .rd_data(rd_data)
  );

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    logic [N_LEVELS-1:0] hit;
    logic [LVL_W-1:0]    lvl;

    pfm_pad_eval #(.RULE(RULES[p])) u_eval (.words(words), .hit(hit));

    pfm_pad_select u_sel (
      .clk(clk), .rst_n(rst_n), .hit(hit),
      .fn_out(fn_out[p*N_SEL +: N_SEL]), .fn_oe(fn_oe[p*N_SEL +: N_SEL]),
      .level_q(lvl), .sel_onehot(pad_sel[p*N_SEL +: N_SEL]),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
    );
    assign pad_level[p*LVL_W +: LVL_W] = lvl;
  end
endmodule

// File: rtl/pinfunc_mux_chk.sv
module pinfunc_mux_chk
  import pfm_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [NUM_CTRL*REG_W-1:0] ctrl_flat,
  input logic [REG_W-1:0]        strap_q,
  input logic [N_PADS*N_SEL-1:0] fn_out,
  input logic [N_PADS*N_SEL-1:0] fn_oe,
  input logic [N_PADS-1:0]       pad_out,
  input logic [N_PADS-1:0]       pad_oe,
  input logic [N_PADS*N_SEL-1:0] pad_sel,
  input logic [N_PADS*LVL_W-1:0] pad_level
);
  // R2: control words only change on a write
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_flat));

  // R3: captured strap word holds once out of reset
  a_r3_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));

  // R9: unchanged control state gives an unchanged level one clock later
  a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(ctrl_flat)) |=> $stable(pad_level));

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    logic [LVL_W-1:0] lv;
    assign lv = pad_level[p*LVL_W +: LVL_W];

    // R7: level stays within 0..fallback
    a_r7_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      lv <= FALLBACK);

    // R9: one-hot select agrees with the encoded level
    a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(pad_sel[p*N_SEL +: N_SEL]) == 1) && pad_sel[p*N_SEL + int'(lv)]);

    // R10: pad takes the selected function's output and enable
    a_r10_route: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out[p] == fn_out[p*N_SEL + int'(lv)]) && (pad_oe[p] == fn_oe[p*N_SEL + int'(lv)]));
  end
endmodule

bind pinfunc_mux pinfunc_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_flat(ctrl_flat), .strap_q(strap_q),
  .fn_out(fn_out), .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_sel(pad_sel), .pad_level(pad_level)
);

// File: tb/test_pinfunc_mux.sv
`timescale 1ns/1ps
module test_pinfunc_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] strap_pins = '0;
  logic [23:0] fn_out = '0;
  logic [23:0] fn_oe = '0;
  logic [3:0]  pad_out, pad_oe;
  logic [23:0] pad_sel;
  logic [11:0] pad_level;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pinfunc_mux i_pinfunc_mux (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .strap_pins(strap_pins),
    .fn_out(fn_out), .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_sel(pad_sel), .pad_level(pad_level)
  );

  // behavioural reference state
  bit [31:0] c_m [4];
  bit [31:0] s_m;
  int        lvl_m [4];

  function automatic int ref_level(int p);
    int mode;
    mode = int'(c_m[3][5:4]);
    case (p)
      0: begin
        if (c_m[0][0]) return 0;
      end
      1: begin
        if (c_m[1][22]) return 0;
        if (c_m[0][12] || s_m[14]) return 1;
      end
      2: begin
        if (c_m[2][3] && c_m[0][15]) return c_m[3][31] ? 1 : 0;
        if (c_m[0][1]) return 2;
      end
      default: begin
        if (mode != 0 && c_m[1][17]) return 0;
        if (mode == 3 && c_m[1][18]) return 1;
        if (c_m[1][17]) return 2;
        if (!s_m[19] && c_m[0][25]) return 3;
        if (c_m[2][7:6] == 2'd2) return 4;
      end
    endcase
    return 5;
  endfunction

  function automatic int ref_read(int a);
    if (a < 4) return int'(c_m[a]);
    if (a == 4) return int'(s_m);
    if (a < 9) return lvl_m[a-5];
    return 0;
  endfunction

  always @(posedge clk) begin
    int nxt [4];
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin lvl_m[p] = 5; c_m[p] = '0; end
      s_m = strap_pins;
    end else begin
      for (int p = 0; p < 4; p++) nxt[p] = ref_level(p);
      if (wr_en && wr_addr < 4) c_m[wr_addr] = wr_data;
      for (int p = 0; p < 4; p++) lvl_m[p] = nxt[p];
    end
  end

  task automatic chk(string tag, int got, int exp);
    nvec++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int p = 0; p < 4; p++) begin
      int lv;
      lv = lvl_m[p];
      chk("R7 level", int'(pad_level[p*3 +: 3]), lv);
      chk("R9 onehot", int'(pad_sel[p*6 +: 6]), 1 << lv);
      chk("R10 out", int'(pad_out[p]), int'(fn_out[p*6 + lv]));
      chk("R10 oe", int'(pad_oe[p]), int'(fn_oe[p*6 + lv]));
    end
    chk(rd_addr >= 5 ? "R11 status read" : "R2 readback", int'(rd_data), ref_read(int'(rd_addr)));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
    tick();
    wr_en = 1'b0;
    tick();
  endtask

  task automatic lvl_is(string tag, int p, int exp);
    chk(tag, int'(pad_level[p*3 +: 3]), exp);
  endtask

  task automatic do_reset(bit [31:0] s);
    rst_n = 1'b0; wr_en = 1'b0; strap_pins = s;
    tick();
    tick();
    for (int p = 0; p < 4; p++) lvl_is("R1 reset level", p, 5);
    rst_n = 1'b1;
    strap_pins = ~s;
    tick();
    rd_addr = 4'd4;
    tick();
    chk("R3 strap held", int'(rd_data), int'(s));
    for (int a = 0; a < 4; a++) begin
      rd_addr = 4'(a);
      tick();
      chk("R1 ctrl cleared", int'(rd_data), 0);
    end
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      bit [31:0] d;
      int r;
      r = int'($urandom_range(0, 9));
      d = $urandom;
      if (r < 5) d = d & 32'h8246_d0fb;
      wr_en   = ($urandom_range(0, 2) == 0);
      wr_addr = 4'($urandom_range(0, 9));
      wr_data = d;
      rd_addr = 4'($urandom_range(0, 10));
      fn_out  = 24'($urandom);
      fn_oe   = 24'($urandom);
      tick();
    end
    wr_en = 1'b0;
  endtask

  initial begin
    // phase 1: strap bit14 set, bit19 clear
    do_reset(32'h0000_4000);
    lvl_is("R8 strap enables pad1 low level", 1, 1);
    lvl_is("R7 pad0 fallback", 0, 5);
    lvl_is("R7 pad3 fallback", 3, 5);

    // R9: write timing, two edges to the level
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h1;
    tick();
    wr_en = 1'b0;
    lvl_is("R9 not yet after commit edge", 0, 5);
    tick();
    lvl_is("R9 level after next edge", 0, 0);

    // R5: shared bits, third bit splits the two levels
    wr(0, 32'h0000_8000);
    wr(2, 32'h8);
    lvl_is("R5 all three terms true", 2, 0);
    wr(3, 32'h8000_0000);
    lvl_is("R5 split bit selects low level", 2, 1);
    wr(2, 32'h0);
    lvl_is("R5 one term false", 2, 5);

    // R6/R4: nonzero mode via either expression
    wr(1, 32'h0002_0000);
    wr(3, 32'h10);
    lvl_is("R6 second expression fires", 3, 0);
    wr(3, 32'h20);
    lvl_is("R6 first expression fires", 3, 0);
    wr(3, 32'h0);
    lvl_is("R4 mode zero drops to shared-bit level", 3, 2);
    wr(1, 32'h0004_0000);
    wr(3, 32'h30);
    lvl_is("R4 exact mode 3", 3, 1);
    wr(3, 32'h20);
    lvl_is("R4 mode 2 is not mode 3", 3, 5);
    wr(2, 32'h80);
    lvl_is("R4 field value 2 at bits 7:6", 3, 4);
    wr(2, 32'hC0);
    lvl_is("R4 field value 3 rejected", 3, 5);
    wr(0, 32'h0200_0000);
    lvl_is("R7 strap-zero term allows level 3", 3, 3);
    lvl_is("R7 pad0 cleared", 0, 5);

    // R8: control writes cannot drop the strap level
    wr(0, 0);
    wr(1, 0);
    lvl_is("R8 strap level survives clears", 1, 1);

    // R2: read-only addresses ignore writes
    wr(4, 32'hFFFF_FFFF);
    wr(6, 32'h0);
    rd_addr = 4'd4;
    tick();
    chk("R2 strap unchanged by write", int'(rd_data), 32'h0000_4000);
    rd_addr = 4'd6;
    tick();
    chk("R11 pad1 status", int'(rd_data), 1);

    // R10: routing of selected slot
    fn_out = 24'h0; fn_oe = 24'h0;
    fn_out[1*6 + 1] = 1'b1; fn_oe[1*6 + 1] = 1'b1;
    tick();
    chk("R10 pad1 out", int'(pad_out[1]), 1);
    chk("R10 pad1 oe", int'(pad_oe[1]), 1);
    chk("R10 pad0 fallback out", int'(pad_out[0]), 0);

    random_run(3000);

    // phase 2: strap bit19 set, bit14 clear
    do_reset(32'h0008_0000);
    lvl_is("R8 no strap, pad1 fallback", 1, 5);
    wr(0, 32'h0200_0000);
    lvl_is("R8 strap bit blocks level 3", 3, 5);
    wr(0, 32'h0000_1000);
    lvl_is("R6 control bit enables pad1 level 1", 1, 1);

    random_run(3000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule